// File: doc/BRIEF.md
# SPI Transfer Engine with Status Flags

This block is a serial peripheral interface core that works either as the clock-driving master or as a selected slave. Software programs it through a small register port. One register holds the character to send and, when read, the last character received. A mode register turns the core on, chooses master or slave, enables interrupts and sets the character length anywhere from one bit up to the full data width. A status register collects the interrupt request, a write-collision flag and a multi-master fault flag. Each flag is cleared by writing one to its bit.

As master, the core makes SCK from a bit-rate tick that an external divider supplies. Every bit of a character takes two ticks. As slave, it brings SCK, the active-low select and MOSI through a synchronizer and follows the edges of the external master. Only one clock mode is built: SCK idles low, data is sampled on the rising edge and shifted on the falling edge, and the most significant bit goes first.

Top module: `spi_xfer_core`

## Requirements
- R1: After reset the mode register and every status flag read 0, `irq` is 0, `sck_out` is 0, and `sck_oe`, `mosi_oe` and `miso_oe` are all 0.
- R2: Register addresses are: 0 = data (a write supplies the transmit character, a read returns the receive register); 1 = mode (bit 0 enable, bit 1 master, bit 2 interrupt enable, bits 6:4 length field), which reads back as written; 2 = status (bit 0 interrupt pending, bit 1 overrun, bit 2 mode fault, top bit busy).
- R3: A length field of 0 selects an 8-bit character, and a value of 1 to 7 selects that many bits. The character is the low N bits of the written value and is sent MSB first. The received bits end up in the low N bits of the receive register, and the upper bits read 0.
- R4: In master mode a data write starts a transfer when the core is idle. On each `bit_tick`, SCK alternately rises (MISO is sampled) and falls (the shift register advances). SCK changes only on the clock after a tick and idles low. MOSI holds the current bit.
- R5: In master mode, the receive register is loaded on the clock of the final falling SCK edge. The interrupt flag is set one clock later, if interrupts are enabled.
- R6: A data write while a transfer is in progress (master busy, or slave selected) sets the overrun flag. The written value is discarded, and the character in flight completes unchanged.
- R7: Writing 1 to status bit 0, 1 or 2 clears that flag. Writing 0 leaves it unchanged.
- R8: In slave mode with select low, the core samples MOSI on rising SCK and shifts on falling SCK. It drives MISO with the MSB of the loaded character, with `miso_oe` asserted only while selected. The receive register is updated after N bits.
- R9: In slave mode the interrupt flag is set when select deasserts. It is not set at the end of each character.
- R10: If an enabled master sees `ss_n_in` low after synchronization, the core sets the mode-fault flag, aborts the transfer and drives SCK low. It releases `sck_oe` and `mosi_oe` until the flag is cleared, and it ignores data writes while the flag is set.
- R11: With interrupt enable at 0, no mode sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| bit_tick | input | 1 | Bit-rate tick from an external divider |
| sck_in | input | 1 | SCK pin input (slave) |
| ss_n_in | input | 1 | Active-low select pin input |
| mosi_in | input | 1 | MOSI pin input (slave) |
| miso_in | input | 1 | MISO pin input (master) |
| sck_out | output | 1 | SCK driven as master |
| sck_oe | output | 1 | SCK output enable |
| mosi_out | output | 1 | MOSI driven as master |
| mosi_oe | output | 1 | MOSI output enable |
| miso_out | output | 1 | MISO driven as slave |
| miso_oe | output | 1 | MISO output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the core with DATA_W = 8 and SYNC_STAGES = 2. With these values the length field is three bits wide, so the zero-means-full-width code, a one-bit character and an odd length each finish within a few dozen ticks. The two-stage synchronizer puts three clocks between a pin change and the flag it causes. The bench therefore waits a fixed margin after each pin change, which keeps the slave and mode-fault sequences short. MISO is looped back to MOSI in master mode, so the receive register must return exactly the masked transmit character.

// File: rtl/spi_pkg.sv
package spi_pkg;
   typedef enum logic [1:0] {
      ADDR_DATA = 2'd0,
      ADDR_MODE = 2'd1,
      ADDR_STAT = 2'd2
   } reg_addr_e;

   localparam int MD_EN     = 0;
   localparam int MD_MASTER = 1;
   localparam int MD_IRQEN  = 2;
   localparam int MD_NB_LSB = 4;

   localparam int ST_IRQ = 0;
   localparam int ST_OVR = 1;
   localparam int ST_COL = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
   parameter int DATA_W = 8,
   parameter int CW     = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master,
   input  logic [CW-1:0]     nbits,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              tick,
   input  logic              fault,
   input  logic              sck_s,
   input  logic              ss_s,
   input  logic              mosi_s,
   input  logic              miso_in,
   output logic              busy,
   output logic              done,
   output logic              slave_end,
   output logic [DATA_W-1:0] rx_data,
   output logic              sck_out,
   output logic              ser_out
);
   logic [DATA_W-1:0] sh, shifted, mask, aligned;
   logic [CW-1:0]     cnt;
   logic              m_busy, phase, samp, sck_r, sck_d, ss_d;

   assign shifted = {sh[DATA_W-2:0], samp};
   assign mask    = {DATA_W{1'b1}} >> (DATA_W - int'(nbits));
   assign aligned = load_data << (DATA_W - int'(nbits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0; cnt <= '0; m_busy <= 1'b0; phase <= 1'b0; samp <= 1'b0;
         sck_r <= 1'b0; sck_d <= 1'b0; ss_d <= 1'b0;
         done <= 1'b0; slave_end <= 1'b0; rx_data <= '0;
      end else begin
         done      <= 1'b0;
         slave_end <= 1'b0;
         sck_d     <= sck_s;
         ss_d      <= ss_s;
         if (load) begin
            sh     <= aligned;
            cnt    <= nbits;
            phase  <= 1'b0;
            sck_r  <= 1'b0;
            m_busy <= master;
         end else if (!en) begin
            m_busy <= 1'b0;
            sck_r  <= 1'b0;
            phase  <= 1'b0;
         end else if (master) begin
            if (fault) begin
               m_busy <= 1'b0;
               sck_r  <= 1'b0;
               phase  <= 1'b0;
            end else if (m_busy && tick) begin
               if (!phase) begin
                  sck_r <= 1'b1;
                  samp  <= miso_in;
                  phase <= 1'b1;
               end else begin
                  sck_r <= 1'b0;
                  phase <= 1'b0;
                  sh    <= shifted;
                  cnt   <= cnt - CW'(1);
                  if (cnt == CW'(1)) begin
                     m_busy  <= 1'b0;
                     done    <= 1'b1;
                     rx_data <= shifted & mask;
                  end
               end
            end
         end else begin
            if (!ss_s) begin
               cnt <= nbits;
            end else if (sck_s && !sck_d) begin
               samp <= mosi_s;
            end else if (!sck_s && sck_d) begin
               sh <= shifted;
               if (cnt == CW'(1)) begin
                  rx_data <= shifted & mask;
                  cnt     <= nbits;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            if (ss_d && !ss_s) slave_end <= 1'b1;
         end
      end
   end

   assign busy    = master ? m_busy : (en & ss_s);
   assign sck_out = sck_r;
   assign ser_out = sh[DATA_W-1];
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core
   import spi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bit_tick,
   input  logic              sck_in,
   input  logic              ss_n_in,
   input  logic              mosi_in,
   input  logic              miso_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              mosi_out,
   output logic              mosi_oe,
   output logic              miso_out,
   output logic              miso_oe,
   output logic              irq
);
   localparam int NBW = $clog2(DATA_W);
   localparam int CW  = $clog2(DATA_W + 1);

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("spi_xfer_core: DATA_W must be a power of two of at least 8");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("spi_xfer_core: SYNC_STAGES must not exceed 4");
   end

   logic [DATA_W-1:0] mode_q, rx_data;
   logic              irq_q, ovr_q, col_q;
   logic              mode_en, mode_master, mode_irq_en;
   logic [NBW-1:0]    nb_field;
   logic [CW-1:0]     nbits;
   logic [2:0]        sync_q;
   logic              sck_s, ss_s, mosi_s;
   logic              wr_data, wr_mode, wr_stat;
   logic              xfer_busy, xfer_done, slave_end, ser_out;
   logic              load, ovr_hit, fault, irq_set;

   assign mode_en     = mode_q[MD_EN];
   assign mode_master = mode_q[MD_MASTER];
   assign mode_irq_en = mode_q[MD_IRQEN];
   assign nb_field    = mode_q[MD_NB_LSB +: NBW];
   assign nbits       = (nb_field == '0) ? CW'(DATA_W) : CW'(nb_field);

   spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck_in, ~ss_n_in, mosi_in}), .q(sync_q)
   );
   assign sck_s  = sync_q[2];
   assign ss_s   = sync_q[1];
   assign mosi_s = sync_q[0];

   assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
   assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);
   assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

   assign ovr_hit = wr_data && mode_en && xfer_busy;
   assign load    = wr_data && mode_en && !xfer_busy && !(mode_master && col_q);
   assign fault   = mode_en && mode_master && ss_s && !col_q;
   assign irq_set = mode_irq_en && (xfer_done ||
                    (slave_end && mode_en && !mode_master));

   spi_engine #(.DATA_W(DATA_W), .CW(CW)) u_engine (
      .clk(clk), .rst_n(rst_n), .en(mode_en), .master(mode_master),
      .nbits(nbits), .load(load), .load_data(reg_wdata), .tick(bit_tick),
      .fault(fault), .sck_s(sck_s), .ss_s(ss_s), .mosi_s(mosi_s),
      .miso_in(miso_in), .busy(xfer_busy), .done(xfer_done),
      .slave_end(slave_end), .rx_data(rx_data), .sck_out(sck_out),
      .ser_out(ser_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         irq_q  <= 1'b0;
         ovr_q  <= 1'b0;
         col_q  <= 1'b0;
      end else begin
         if (wr_mode) mode_q <= reg_wdata;
         if (irq_set) irq_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_IRQ]) irq_q <= 1'b0;
         if (ovr_hit) ovr_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_OVR]) ovr_q <= 1'b0;
         if (fault) col_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_COL]) col_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_DATA: reg_rdata = rx_data;
         ADDR_MODE: reg_rdata = mode_q;
         ADDR_STAT: begin
            reg_rdata[ST_IRQ]   = irq_q;
            reg_rdata[ST_OVR]   = ovr_q;
            reg_rdata[ST_COL]   = col_q;
            reg_rdata[DATA_W-1] = xfer_busy;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign sck_oe   = mode_en && mode_master && !col_q;
   assign mosi_oe  = sck_oe;
   assign mosi_out = ser_out;
   assign miso_out = ser_out;
   assign miso_oe  = mode_en && !mode_master && ss_s;
   assign irq      = irq_q;
endmodule

// File: rtl/spi_xfer_core_chk.sv
module spi_xfer_core_chk
   import spi_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_addr,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq,
   input logic              ovr,
   input logic              col,
   input logic              busy,
   input logic              en,
   input logic              irq_en,
   input logic              sck_out,
   input logic              bit_tick
);
   // R6
   ovr_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_DATA && en && busy) |=> ovr);

   // R7
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_IRQ])) |=> irq);

   // R7
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_OVR])) |=> ovr);

   // R10
   fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col) |-> (!sck_out && !busy));

   // R4
   sck_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_out) |-> $past(bit_tick));

   // R11
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_en));
endmodule

bind spi_xfer_core spi_xfer_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .irq(irq_q), .ovr(ovr_q), .col(col_q),
   .busy(xfer_busy), .en(mode_en), .irq_en(mode_irq_en),
   .sck_out(sck_out), .bit_tick(bit_tick)
);

// File: tb/test_spi_xfer_core.sv
`timescale 1ns/1ps
module test_spi_xfer_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       bit_tick = 1'b0;
   logic       sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;
   logic       miso_in;
   logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, irq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit model_on = 1'b0, tick_on = 1'b0, finished = 1'b0;

   always #5 clk = ~clk;

   assign miso_in = mosi_out;

   spi_xfer_core i_spi_xfer_core (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_tick(bit_tick),
      .sck_in(sck_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in), .miso_in(miso_in),
      .sck_out(sck_out), .sck_oe(sck_oe), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
      .miso_out(miso_out), .miso_oe(miso_oe), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // free-running bit tick: one clock high in every four
   int tick_ph = 0;
   always @(negedge clk) begin
      tick_ph = (tick_ph + 1) % 4;
      bit_tick = tick_on && (tick_ph == 0);
   end

   // behavioural master-mode reference
   int  m_q[$];
   bit  m_busy, m_phase, m_sck, m_irq, m_pend;
   logic [7:0] m_mode;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete(); m_busy = 0; m_phase = 0; m_sck = 0;
         m_irq = 0; m_pend = 0; m_mode = 8'h00;
      end else begin
         bit was_busy;
         if (m_pend) begin m_irq = 1; m_pend = 0; end
         was_busy = m_busy;
         if (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) m_irq = 0;
         if (reg_wr && reg_addr == 2'd0 && !was_busy && m_mode[0] && m_mode[1]) begin
            int nb;
            nb = (m_mode[6:4] == 3'd0) ? 8 : int'(m_mode[6:4]);
            m_q.delete();
            for (int i = nb - 1; i >= 0; i--) m_q.push_back(int'(reg_wdata[i]));
            m_busy = 1; m_phase = 0; m_sck = 0;
         end else if (was_busy && bit_tick) begin
            if (!m_phase) begin
               m_sck = 1; m_phase = 1;
            end else begin
               m_sck = 0; m_phase = 0;
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin
                  m_busy = 0;
                  if (m_mode[2]) m_pend = 1;
               end
            end
         end
         if (reg_wr && reg_addr == 2'd1) m_mode = reg_wdata;
      end
      #1;
      if (model_on && rst_n) begin
         chk("R4 sck_out vs model", 32'(sck_out), 32'(m_sck));
         chk("R5 irq vs model", 32'(irq), 32'(m_irq));
         if (m_busy) chk("R4 mosi_out vs model", 32'(mosi_out), 32'(m_q[0]));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] tx, rxv;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      rd(2'd2, v); chk("R1 status after reset", 32'(v), 32'h0);
      rd(2'd1, v); chk("R1 mode after reset", 32'(v), 32'h0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 sck_out", 32'(sck_out), 0);
      chk("R1 output enables", 32'({sck_oe, mosi_oe, miso_oe}), 0);

      // R2 mode readback, master 8-bit with interrupts
      tick_on = 1'b1;
      model_on = 1'b1;
      wr(2'd1, 8'h07);
      rd(2'd1, v); chk("R2 mode readback", 32'(v), 32'h07);
      chk("R2 sck_oe in master", 32'(sck_oe), 1);

      // R3 R5 full-width character (length field 0)
      wr(2'd0, 8'hA5);
      wait_cyc(80);
      rd(2'd0, v); chk("R3 rx 8-bit loopback", 32'(v), 32'hA5);
      rd(2'd2, v); chk("R5 irq status bit", 32'(v[0]), 1);
      chk("R5 irq pin", 32'(irq), 1);

      // R7 write-one-to-clear
      wr(2'd2, 8'h00);
      chk("R7 zero write keeps irq", 32'(irq), 1);
      wr(2'd2, 8'h01);
      chk("R7 one clears irq", 32'(irq), 0);

      // R3 three-bit character
      wr(2'd1, 8'h37);
      wr(2'd0, 8'hFD);
      wait_cyc(60);
      rd(2'd0, v); chk("R3 rx 3-bit", 32'(v), 32'h05);
      wr(2'd2, 8'h01);

      // R3 one-bit character
      wr(2'd1, 8'h17);
      wr(2'd0, 8'h01);
      wait_cyc(30);
      rd(2'd0, v); chk("R3 rx 1-bit", 32'(v), 32'h01);
      wr(2'd2, 8'h01);

      // R6 overrun
      wr(2'd1, 8'h07);
      wr(2'd0, 8'h3C);
      wait_cyc(10);
      wr(2'd0, 8'hFF);
      rd(2'd2, v); chk("R6 ovr set", 32'(v[1]), 1);
      chk("R6 busy during transfer", 32'(v[7]), 1);
      wait_cyc(80);
      rd(2'd0, v); chk("R6 char in flight unchanged", 32'(v), 32'h3C);
      wr(2'd2, 8'h02);
      rd(2'd2, v); chk("R7 ovr cleared", 32'(v[1]), 0);
      wr(2'd2, 8'h01);

      // R11 master with interrupts off
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h5A);
      wait_cyc(80);
      rd(2'd0, v); chk("R11 rx still delivered", 32'(v), 32'h5A);
      chk("R11 no irq when disabled", 32'(irq), 0);

      // R10 mode fault
      model_on = 1'b0;
      wr(2'd0, 8'hC3);
      wait_cyc(10);
      ss_n_in = 1'b0;
      wait_cyc(6);
      rd(2'd2, v);
      chk("R10 col flag", 32'(v[2]), 1);
      chk("R10 transfer aborted", 32'(v[7]), 0);
      chk("R10 sck released", 32'({sck_oe, mosi_oe}), 0);
      chk("R10 sck low", 32'(sck_out), 0);
      wr(2'd0, 8'hFF);
      wait_cyc(20);
      rd(2'd2, v); chk("R10 write ignored while col", 32'(v[7]), 0);
      chk("R10 sck stays low", 32'(sck_out), 0);
      ss_n_in = 1'b1;
      wait_cyc(5);
      wr(2'd2, 8'h04);
      rd(2'd2, v); chk("R7 col cleared", 32'(v[2]), 0);
      chk("R10 sck_oe restored", 32'(sck_oe), 1);

      // R8 R9 slave, 8 bits, interrupts on
      tick_on = 1'b0;
      wr(2'd1, 8'h05);
      tx = 8'h96; rxv = 8'h5A;
      wr(2'd0, tx);
      chk("R8 miso_oe idle", 32'(miso_oe), 0);
      ss_n_in = 1'b0;
      wait_cyc(6);
      chk("R8 miso_oe selected", 32'(miso_oe), 1);
      for (int i = 0; i < 8; i++) begin
         chk("R8 miso bit", 32'(miso_out), 32'(tx[7-i]));
         mosi_in = rxv[7-i];
         wait_cyc(2);
         sck_in = 1'b1; wait_cyc(6);
         sck_in = 1'b0; wait_cyc(6);
      end
      rd(2'd0, v); chk("R8 slave rx", 32'(v), 32'h5A);
      chk("R9 no irq before deselect", 32'(irq), 0);
      wr(2'd0, 8'h11);
      rd(2'd2, v); chk("R6 slave ovr", 32'(v[1]), 1);
      ss_n_in = 1'b1;
      wait_cyc(6);
      chk("R9 irq on deselect", 32'(irq), 1);
      chk("R8 miso released", 32'(miso_oe), 0);
      wr(2'd2, 8'h03);

      // R3 R11 slave, 4 bits, interrupts off
      wr(2'd1, 8'h41);
      tx = 8'h0B; rxv = 8'h06;
      wr(2'd0, tx);
      ss_n_in = 1'b0;
      wait_cyc(6);
      for (int i = 0; i < 4; i++) begin
         chk("R3 slave 4-bit miso", 32'(miso_out), 32'(tx[3-i]));
         mosi_in = rxv[3-i];
         wait_cyc(2);
         sck_in = 1'b1; wait_cyc(6);
         sck_in = 1'b0; wait_cyc(6);
      end
      rd(2'd0, v); chk("R3 slave rx 4-bit", 32'(v), 32'h06);
      ss_n_in = 1'b1;
      wait_cyc(6);
      chk("R11 no slave irq when disabled", 32'(irq), 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule